// File: doc/BRIEF.md
# Signed-Digit to BCD Result Converter

The converter is the last stage of a sequential decimal multiplier. The accumulation loop finishes with a result held in redundant signed-digit form. Each digit position carries a small residual, and a transfer arrives from the position below it. This block turns that result into ordinary packed BCD. Each signed digit is formed with a 4-bit lookahead adder. A per-digit borrow generate/propagate pair follows from the sign and the zero test of that digit. A logarithmic prefix network then resolves every incoming borrow at once, so no borrow ripples digit by digit. Finally, each digit gets a conditional +10 correction.

The block is a two-stage pipeline with one result per clock. Stage one forms the signed digits and their generate/propagate pairs and registers them. Stage two runs the prefix network and the correction, then registers the BCD word. A flag marks each result as valid. The value presented is assumed non-negative and smaller than 10 to the power of the digit count. Negative results are not handled.

Top module: `rbc_converter`

## Requirements
- R1: Digit i takes its residual from `res_i[4i+3:4i]`, read as a two's-complement value in [-5,4]. For i ≥ 1 it also takes a transfer from `xfer_i[2(i-1)+1:2(i-1)]`, read in offset code: a code c means c−1, so 0,1,2,3 mean -1,0,1,2. Digit 0 receives no transfer. The input value is the sum over i of (residual + transfer) × 10^i.
- R2: When `valid_o` is high, `bcd_o[4i+3:4i]` holds decimal digit i of the input value, in the range 0 to 9, with digit 0 in the lowest nibble.
- R3: `valid_o` goes high after the second rising clock edge, counting the edge that samples `valid_i` high. It stays low two edges after a cycle in which `valid_i` is low. Back-to-back inputs give back-to-back results.
- R4: While `valid_o` is low, `bcd_o` keeps its last value. Data presented with `valid_i` low has no effect on it.
- R5: While `rst_n` is low, `valid_o` is 0 and `bcd_o` is all zeros.
- R6: A negative digit whose borrow has to pass through every zero digit above it is resolved correctly in one pass. For example, 10^(N−1) − 1 gives a 0 in the top digit and 9 in every other digit.
- R7: A zero signed digit that receives no borrow stays 0 in the output. A digit of the extreme value −6 yields 4 when no borrow enters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word valid |
| res_i | input | 4*NDIG | Per-digit residuals, two's complement |
| xfer_i | input | 2*(NDIG-1) | Transfers into digits 1..NDIG-1, offset code |
| valid_o | output | 1 | Result valid |
| bcd_o | output | 4*NDIG | Converted packed BCD result |

## Verification
The checker takes for granted that every residual sampled with `valid_i` high lies in [-5,4]. It also relies on the encoded value being non-negative and fitting in the digit count, since no borrow can leave the top digit. The random stimulus draws residuals and transfers uniformly within their legal ranges. It keeps an encoding only when its arithmetic value is non-negative. The maximum of all-positive digits always fits the width. Idle cycles drive arbitrary bits, including out-of-range residuals, to show that such data is ignored.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
    localparam int DIGIT_W = 4;
    localparam int XFER_W  = 2;
    localparam int RES_MIN = -5;
    localparam int RES_MAX = 4;
    localparam logic [DIGIT_W-1:0] BCD_MAX  = 4'd9;
    localparam logic [DIGIT_W-1:0] RADIX_FIX = 4'd10;

    // Offset-coded transfer (code c means c-1) to a 4-bit two's-complement value.
    function automatic logic [DIGIT_W-1:0] xfer_to_sdig(input logic [XFER_W-1:0] code);
        return {2'b00, code} + 4'hF;
    endfunction
endpackage

// File: rtl/rbc_digit_form.sv
module rbc_digit_form
    import rbc_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int DW = DIGIT_W * NDIG,
    localparam int XW = XFER_W * (NDIG - 1)
) (
    input  logic [DW-1:0]   res_i,
    input  logic [XW-1:0]   xfer_i,
    output logic [DW-1:0]   sdig_o,
    output logic [NDIG-1:0] bgen_o,   // generate of digit i-1 (index 0 is zero)
    output logic [NDIG-1:0] bprop_o   // propagate of digit i-1 (index 0 is zero)
);
    logic [DIGIT_W-1:0] sum_w [NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [DIGIT_W-1:0] opa, opb, gk, pk, cy;
        assign opa = res_i[DIGIT_W*i +: DIGIT_W];
        if (i == 0) begin : g_lsd
            assign opb = '0;
        end else begin : g_upper
            assign opb = xfer_to_sdig(xfer_i[XFER_W*(i-1) +: XFER_W]);
        end
        // 4-bit carry-lookahead adder
        assign gk = opa & opb;
        assign pk = opa ^ opb;
        assign cy[0] = 1'b0;
        assign cy[1] = gk[0];
        assign cy[2] = gk[1] | (pk[1] & gk[0]);
        assign cy[3] = gk[2] | (pk[2] & gk[1]) | (pk[2] & pk[1] & gk[0]);
        assign sum_w[i] = pk ^ cy;
        assign sdig_o[DIGIT_W*i +: DIGIT_W] = sum_w[i];
    end

    assign bgen_o[0]  = 1'b0;
    assign bprop_o[0] = 1'b0;
    for (genvar i = 1; i < NDIG; i++) begin : g_gp
        assign bgen_o[i]  = sum_w[i-1][DIGIT_W-1];
        assign bprop_o[i] = (sum_w[i-1] == '0);
    end
endmodule

// File: rtl/rbc_borrow_tree.sv
module rbc_borrow_tree #(
    parameter int NDIG = 8,
    localparam int LVL = (NDIG > 1) ? $clog2(NDIG) : 0,
    localparam int PLV = (LVL > 0) ? LVL - 1 : 0
) (
    input  logic [NDIG-1:0] bgen_i,
    input  logic [NDIG-1:0] bprop_i,
    input  logic            bin_i,
    output logic [NDIG-1:0] borrow_o
);
    logic [NDIG-1:0] gl [0:LVL];
    logic [NDIG-1:0] pl [0:PLV];

    assign gl[0] = bgen_i;
    assign pl[0] = bprop_i;

    for (genvar k = 0; k < LVL; k++) begin : g_lvl
        localparam int DIST = 1 << k;
        for (genvar i = 0; i < NDIG; i++) begin : g_node
            if (i >= DIST) begin : g_comb
                assign gl[k+1][i] = gl[k][i] | (pl[k][i] & gl[k][i-DIST]);
                if (k + 1 <= PLV) begin : g_p
                    assign pl[k+1][i] = pl[k][i] & pl[k][i-DIST];
                end
            end else begin : g_edge
                assign gl[k+1][i] = gl[k][i] | (pl[k][i] & bin_i);
                if (k + 1 <= PLV) begin : g_p
                    assign pl[k+1][i] = pl[k][i];
                end
            end
        end
    end

    assign borrow_o = gl[LVL];
endmodule

// File: rtl/rbc_digit_fix.sv
module rbc_digit_fix
    import rbc_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int DW = DIGIT_W * NDIG
) (
    input  logic [DW-1:0]   sdig_i,
    input  logic [NDIG-1:0] borrow_i,
    output logic [DW-1:0]   bcd_o
);
    for (genvar i = 0; i < NDIG; i++) begin : g_fix
        logic [DIGIT_W-1:0] d;
        logic [DIGIT_W:0]   diff;
        assign d    = sdig_i[DIGIT_W*i +: DIGIT_W];
        assign diff = {d[DIGIT_W-1], d} - {{DIGIT_W{1'b0}}, borrow_i[i]};
        assign bcd_o[DIGIT_W*i +: DIGIT_W] = diff[DIGIT_W] ? (diff[DIGIT_W-1:0] + RADIX_FIX)
                                                           : diff[DIGIT_W-1:0];
    end
endmodule

// File: rtl/rbc_converter.sv
module rbc_converter
    import rbc_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int DW = DIGIT_W * NDIG,
    localparam int XW = XFER_W * (NDIG - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [DW-1:0] res_i,
    input  logic [XW-1:0] xfer_i,
    output logic          valid_o,
    output logic [DW-1:0] bcd_o
);
    typedef struct packed {
        logic            s1_vld;
        logic [DW-1:0]   s1_dig;
        logic [NDIG-1:0] s1_bg;
        logic [NDIG-1:0] s1_bp;
        logic            out_vld;
        logic [DW-1:0]   out_bcd;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [DW-1:0]   form_dig;
    logic [NDIG-1:0] form_bg, form_bp;
    logic [NDIG-1:0] borrow;
    logic [DW-1:0]   fixed_bcd;

    rbc_digit_form #(.NDIG(NDIG)) form_i (
        .res_i   (res_i),
        .xfer_i  (xfer_i),
        .sdig_o  (form_dig),
        .bgen_o  (form_bg),
        .bprop_o (form_bp)
    );

    rbc_borrow_tree #(.NDIG(NDIG)) tree_i (
        .bgen_i   (st_q.s1_bg),
        .bprop_i  (st_q.s1_bp),
        .bin_i    (1'b0),
        .borrow_o (borrow)
    );

    rbc_digit_fix #(.NDIG(NDIG)) fix_i (
        .sdig_i   (st_q.s1_dig),
        .borrow_i (borrow),
        .bcd_o    (fixed_bcd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.s1_vld  = valid_i;
        if (valid_i) begin
            st_d.s1_dig = form_dig;
            st_d.s1_bg  = form_bg;
            st_d.s1_bp  = form_bp;
        end
        st_d.out_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.out_bcd = fixed_bcd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.out_vld;
    assign bcd_o   = st_q.out_bcd;
endmodule

// File: rtl/rbc_converter_chk.sv
module rbc_converter_chk
    import rbc_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int DW = DIGIT_W * NDIG,
    localparam int XW = XFER_W * (NDIG - 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [DW-1:0] res_i,
    input logic [XW-1:0] xfer_i,
    input logic          valid_o,
    input logic [DW-1:0] bcd_o
);
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assert_res_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i |-> ($signed(res_i[DIGIT_W*i +: DIGIT_W]) >= RES_MIN &&
                         $signed(res_i[DIGIT_W*i +: DIGIT_W]) <= RES_MAX));
        assert_bcd_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (bcd_o[DIGIT_W*i +: DIGIT_W] <= BCD_MAX));
    end

    assert_valid_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> ##2 valid_o);
    assert_idle_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> ##2 !valid_o);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(bcd_o));

    wire unused_ok = ^xfer_i;
endmodule

bind rbc_converter rbc_converter_chk #(.NDIG(NDIG)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .res_i   (res_i),
    .xfer_i  (xfer_i),
    .valid_o (valid_o),
    .bcd_o   (bcd_o)
);

// File: tb/rbc_converter_tb_top.sv
`timescale 1ns/1ps
module rbc_converter_tb_top;
    localparam int NDIG = 8;
    localparam int DW = 4 * NDIG;
    localparam int XW = 2 * (NDIG - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [DW-1:0] res_i = '0;
    logic [XW-1:0] xfer_i = '0;
    logic          valid_o;
    logic [DW-1:0] bcd_o;

    int n_run = 0;
    int n_fail = 0;
    int w_a [NDIG];
    int t_a [NDIG];
    bit pv1 = 0, pv2 = 0;
    logic [DW-1:0] pb1 = '0, pb2 = '0, hold = '0;
    string pr1 = "R2", pr2 = "R2";
    bit finished = 0;

    always #5 clk = ~clk;

    rbc_converter #(.NDIG(NDIG)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .res_i(res_i),
        .xfer_i(xfer_i), .valid_o(valid_o), .bcd_o(bcd_o)
    );

    function automatic longint enc_value();
        longint s = 0, p = 1;
        for (int i = 0; i < NDIG; i++) begin
            s += longint'(w_a[i] + ((i > 0) ? t_a[i] : 0)) * p;
            p *= 10;
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] expect_bcd();
        longint s = enc_value();
        logic [DW-1:0] r = '0;
        for (int i = 0; i < NDIG; i++) begin
            r[4*i +: 4] = 4'(s % 10);
            s /= 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_all(input int w, input int t);
        for (int i = 0; i < NDIG; i++) begin
            w_a[i] = w;
            t_a[i] = (i > 0) ? t : 0;
        end
    endtask

    task automatic gen_random();
        do begin
            for (int i = 0; i < NDIG; i++) begin
                w_a[i] = int'($urandom_range(9, 0)) - 5;
                t_a[i] = (i > 0) ? int'($urandom_range(3, 0)) - 1 : 0;
            end
        end while (enc_value() < 0);
    endtask

    // Check the result due now, then drive the next input at this falling edge.
    task automatic cycle(input bit v, input string req);
        @(negedge clk);
        check(valid_o === pv2, "R3", {{(DW-1){1'b0}}, valid_o}, {{(DW-1){1'b0}}, pv2});
        if (pv2) begin
            check(bcd_o === pb2, pr2, bcd_o, pb2);
            hold = pb2;
        end else begin
            check(bcd_o === hold, "R4", bcd_o, hold);
        end
        pv2 = pv1; pb2 = pb1; pr2 = pr1;
        valid_i = v;
        if (v) begin
            for (int i = 0; i < NDIG; i++) begin
                res_i[4*i +: 4] = 4'(w_a[i]);
                if (i > 0) xfer_i[2*(i-1) +: 2] = 2'(t_a[i] + 1);
            end
            pb1 = expect_bcd();
            pr1 = req;
        end else begin
            res_i  = DW'({$urandom, $urandom});
            xfer_i = XW'($urandom);
        end
        pv1 = v;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0 && bcd_o === '0, "R5", bcd_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0 && bcd_o === '0, "R5", bcd_o, '0);

        // all zero digits, back to back with following cases
        set_all(0, 0); cycle(1, "R2");
        // R6: borrow runs through every zero digit: 10^(N-1) - 1
        set_all(0, 0); w_a[0] = -1; w_a[NDIG-1] = 1; cycle(1, "R6");
        // largest positive digits
        set_all(4, 2); cycle(1, "R2");
        // R7: zero digits without borrow stay zero
        set_all(0, 0); w_a[0] = 2; w_a[NDIG-1] = 3; cycle(1, "R7");
        // R7: digit -6 with no borrow entering yields 4
        set_all(0, 0); w_a[0] = 1; w_a[1] = -5; t_a[1] = -1; w_a[NDIG-1] = 2; cycle(1, "R7");
        // R6: borrow chain from a mid digit
        set_all(0, 0); w_a[3] = -5; w_a[NDIG-1] = 1; cycle(1, "R6");
        repeat (4) cycle(0, "R4");

        // R1/R2/R3/R4: random legal encodings mixed with idle garbage
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(3, 0) != 0) begin
                gen_random();
                cycle(1, "R1");
            end else begin
                cycle(0, "R4");
            end
        end
        repeat (3) cycle(0, "R4");

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule